// File: doc/BRIEF.md
# Overwrite-Oldest Sample Ring with Fill Trigger

This block is a single-channel circular buffer for converter samples. It holds 64 words of 16 bits. A producer pushes one sample per cycle with a valid strobe, and a consumer pops samples in arrival order. When the buffer is already full, an incoming sample is never refused. Instead the oldest stored sample is dropped to make room, and a one-cycle overflow pulse reports the loss.

The consumer does not poll for "not empty". It programs a fill threshold between 1 and 64. A ready flag stays high while the number of stored samples is at or above that threshold, so a reader can wait for a batch. A threshold outside the legal range is refused with a one-cycle error pulse. A synchronous clear re-initialises the channel: the buffer is emptied and the threshold returns to 1.

Top module: `sample_ring`

## Requirements
- R1: After reset, count is 0, empty is 1, ready is 0, overflow and cfg_err are 0, and the threshold is 1.
- R2: Each write stores wr_data at the tail. Samples are popped in the order they were written, including across the wrap of the storage index from 63 to 0. rd_data always shows the oldest stored sample while empty is 0.
- R3: A write with no pop while count is 64 drops the oldest sample and keeps count at 64. overflow is 1 for exactly the following cycle.
- R4: ready equals (count >= threshold) at every cycle, and it follows changes to either count or threshold.
- R5: A configuration write with a level from 1 to 64 inclusive sets the threshold from the next cycle, and cfg_err stays 0.
- R6: A configuration write with level 0 or level 65..127 pulses cfg_err for the following cycle and leaves the threshold unchanged.
- R7: A pop on a non-empty buffer removes the oldest sample and lowers count by one. empty is 1 exactly when count is 0.
- R8: A pop while count is 0 is ignored. Count stays 0. If a write arrives in the same cycle, that write is still stored.
- R9: A write and a pop in the same cycle on a full buffer apply the pop first. The oldest sample leaves, the new sample is appended, count stays 64, and overflow stays 0.
- R10: clear empties the buffer and restores the threshold to 1 from the next cycle. It overrides any write, pop or legal configuration write in the same cycle.
- R11: A write and a pop in the same cycle on a partly filled buffer leave count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous channel re-initialise |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Sample to store |
| rd_pop | input | 1 | Remove the oldest sample |
| rd_data | output | 16 | Oldest stored sample |
| empty | output | 1 | No samples stored |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_level | input | 7 | Requested threshold |
| cfg_err | output | 1 | Pulse: requested threshold was illegal |
| count | output | 7 | Number of stored samples, 0..64 |
| ready | output | 1 | count is at or above the threshold |
| overflow | output | 1 | Pulse: a sample was dropped |

## Verification
The properties assume that clear, wr_en, rd_pop and cfg_we carry defined values at every clock edge after reset, and that cfg_level is defined whenever cfg_we is high. No other input protocol is assumed, because every combination of strobes is legal, including a pop on an empty buffer and a write on a full one. The random stimulus drives fully defined values on every cycle. It biases writes above pops so that long stretches at 64 entries occur, and it draws configuration levels across the whole 7-bit range so that illegal values appear often.

// File: rtl/sample_ring.sv
module sample_ring #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         wr_en,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         rd_pop,
  output logic [WIDTH-1:0]             rd_data,
  output logic                         empty,
  input  logic                         cfg_we,
  input  logic [$clog2(DEPTH+1)-1:0]   cfg_level,
  output logic                         cfg_err,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ready,
  output logic                         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    trig;

  wire do_pop    = rd_pop && (count != '0);
  wire drop      = wr_en && (count == FULL) && !do_pop;
  wire adv_rd    = do_pop || drop;
  wire level_bad = (cfg_level == '0) || (cfg_level > FULL);

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign ready   = (count >= trig);

  always_ff @(posedge clk) begin
    if (wr_en && !clear) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      trig     <= CW'(1);
      overflow <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_we && level_bad;
      if (clear) begin
        wr_ptr   <= '0;
        rd_ptr   <= '0;
        count    <= '0;
        trig     <= CW'(1);
        overflow <= 1'b0;
      end else begin
        overflow <= drop;
        if (cfg_we && !level_bad) trig <= cfg_level;
        if (wr_en)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (adv_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        if (wr_en && !do_pop && !drop) count <= count + 1'b1;
        else if (!wr_en && do_pop)     count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sample_ring_chk.sv
module sample_ring_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clear,
  input logic                       wr_en,
  input logic                       rd_pop,
  input logic                       cfg_we,
  input logic [$clog2(DEPTH+1)-1:0] cfg_level,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       ready,
  input logic                       empty,
  input logic                       overflow,
  input logic                       cfg_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);  // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_pop && !clear && count == FULL) |=> (overflow && count == FULL));  // R3

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || rd_pop || clear || count != FULL) |=> !overflow);  // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && empty && !wr_en && !clear) |=> empty);  // R8

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !ready && !overflow));  // R10

  AST_BAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_level == '0 || cfg_level > FULL)) |=> cfg_err);  // R6

  AST_GOOD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_level != '0 && cfg_level <= FULL) |=> !cfg_err);  // R5

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                count + 1'b1 == $past(count)));  // R11
endmodule

bind sample_ring sample_ring_chk #(.DEPTH(DEPTH)) u_sample_ring_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .rd_pop(rd_pop),
  .cfg_we(cfg_we), .cfg_level(cfg_level), .count(count), .ready(ready),
  .empty(empty), .overflow(overflow), .cfg_err(cfg_err)
);

// File: tb/test_sample_ring.sv
`timescale 1ns/1ps
module test_sample_ring;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, wr_en = 1'b0, rd_pop = 1'b0, cfg_we = 1'b0;
  logic [15:0] wr_data = '0;
  logic [6:0]  cfg_level = '0;
  logic [15:0] rd_data;
  logic [6:0]  count;
  logic empty, cfg_err, ready, overflow;

  int total = 0, bad = 0;
  bit done = 0;
  int q[$];
  int trig = 1;
  bit e_ovf = 0, e_err = 0;

  always #10 clk = ~clk;

  sample_ring i_sample_ring (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .empty(empty), .cfg_we(cfg_we),
    .cfg_level(cfg_level), .cfg_err(cfg_err), .count(count), .ready(ready),
    .overflow(overflow)
  );

  function automatic bit illegal(int l);
    return (l < 1) || (l > 64);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "count", count, q.size());
    chk(tag, "empty", empty, q.size() == 0);
    chk("R4", "ready", ready, q.size() >= trig);
    chk(tag, "overflow", overflow, e_ovf);
    chk(tag, "cfg_err", cfg_err, e_err);
    if (q.size() > 0) chk(tag, "rd_data", rd_data, q[0]);
  endtask

  task automatic step(string tag, bit w, int d, bit p, bit cw, int lv, bit c);
    wr_en = w; wr_data = 16'(d); rd_pop = p; cfg_we = cw; cfg_level = 7'(lv); clear = c;
    e_err = cw && illegal(lv);
    e_ovf = 0;
    if (c) begin
      q.delete();
      trig = 1;
    end else begin
      if (cw && !illegal(lv)) trig = lv;
      if (p && q.size() > 0) void'(q.pop_front());
      if (w) begin
        if (q.size() == 64) begin
          void'(q.pop_front());
          e_ovf = 1;
        end
        q.push_back(d & 16'hffff);
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R8: pop on empty ignored; write+pop on empty still stores
    step("R8", 0, 0, 1, 0, 0, 0);
    step("R8", 1, 16'h1111, 1, 0, 0, 0);
    step("R7", 0, 0, 1, 0, 0, 0);

    // R5 / R6: legal and illegal thresholds, ready follows (R4)
    step("R5", 0, 0, 0, 1, 3, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R6", 0, 0, 0, 1, 65, 0);
    step("R6", 0, 0, 0, 1, 127, 0);
    for (int i = 0; i < 3; i++) step("R4", 1, 16'h2000 + i, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 64, 0);
    step("R11", 1, 16'h2100, 1, 0, 0, 0);

    // R2 / R3: fill to 64, overflow several times across the wrap
    for (int i = 0; i < 70; i++) step("R3", 1, 16'h3000 + i, 0, 0, 0, 0);
    // R9: write+pop while full
    for (int i = 0; i < 4; i++) step("R9", 1, 16'h4000 + i, 1, 0, 0, 0);
    // R7 / R2: drain in order
    for (int i = 0; i < 66; i++) step("R2", 0, 0, 1, 0, 0, 0);

    // R10: clear overrides write, pop and legal config
    for (int i = 0; i < 5; i++) step("R2", 1, 16'h5000 + i, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 8, 0);
    step("R10", 1, 16'h5555, 1, 1, 2, 1);
    step("R10", 1, 16'h5600, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit w = ($urandom_range(0, 99) < 60);
      bit p = ($urandom_range(0, 99) < 40);
      bit cw = (r < 6);
      bit c = (r == 99);
      step("R4", w, $urandom_range(0, 65535), p, cw, $urandom_range(0, 127), c);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule